// File: doc/BRIEF.md
# Byte-Register Multiply/Divide Unit

This block gives a host a 16×16 multiplier and a 32÷16 divider that it drives entirely through byte-wide registers. The host writes operand bytes one at a time over a simple address, write-data and write-strobe port. Writing the top byte of the multiplier starts a multiply. Writing the top byte of the divisor starts a divide. When the result is ready, it sits in four result bytes and two remainder bytes, and a completion flag is raised.

A control register chooses between signed and unsigned arithmetic. Any write to that register also wipes the whole unit. The multiply finishes one cycle after it is launched. The divide runs on a restoring divider that takes one quotient bit per cycle. The completion flag is read-to-clear: the host polls it until it sees 0x80, and that read itself drops it back to zero.

Top module: `muldiv_regs`

## Requirements
- R1: After reset every register reads 0x00 and the status byte reads 0x00.
- R2: Operand bytes are stored little-endian and read back at their own addresses. Addresses 0x0–0x3 hold the 32-bit dividend, whose lower two bytes are also the multiplicand. Addresses 0x4–0x5 hold the multiplier and 0x6–0x7 the divisor. Addresses 0x8–0xB read the 32-bit result, 0xC–0xD the 16-bit remainder, 0xE the control byte and 0xF the status byte.
- R3: A write to address 0x5 launches a multiply of the multiplicand by the multiplier. The 32-bit product appears at 0x8–0xB.
- R4: Bit 0 of the control byte selects the arithmetic: 1 means two's-complement signed, 0 means unsigned. This applies to both multiply and divide.
- R5: A write to address 0x7 launches a divide. The quotient appears at 0x8–0xB and the remainder at 0xC–0xD.
- R6: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R7: With a zero divisor, the quotient is 0 and the remainder equals the low 16 bits of the dividend.
- R8: The status byte reads 0x00 while an operation is in progress. It becomes 0x80 only once the result and remainder are final, within 40 cycles of the launch.
- R9: A status read that returns 0x80 clears the flag, so the next status read returns 0x00.
- R10: A write to address 0xE does four things: it clears every operand, result and remainder byte, aborts any running operation, clears the flag, and stores the written value as the control byte.
- R11: A launch that arrives while an operation is running restarts it with the operand values current at that moment.
- R12: Writes to the result, remainder and status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe; qualifies the read-to-clear of the status byte |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
The assertions watch the flag's protocol on every cycle. The flag never coexists with a running operation. It rises only out of a busy cycle and falls after a status read. A launch or restart always leaves the unit busy with the flag down, and a control write always leaves result and remainder cleared. The arithmetic itself can only be shown by the bench's scenarios, which compare against independently computed values: products and quotients in both signednesses, truncation and remainder sign, the zero divisor, and restart with changed operands. The bench scenarios also cover the ignored writes and the abort of a divide by a control write.

// File: rtl/muldiv_regs.sv
module muldiv_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int DW = 32;
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW) + 1;
  localparam logic [3:0] A_MPY_HI = 4'h5;
  localparam logic [3:0] A_DVS_HI = 4'h7;
  localparam logic [3:0] A_CTRL   = 4'hE;
  localparam logic [3:0] A_STAT   = 4'hF;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DLD, S_DIV, S_FIN} state_t;

  state_t        state;
  logic [DW-1:0] dvd, res, quo;
  logic [HW-1:0] mpy, dvs, rem, acc, dmag;
  logic [7:0]    ctrl;
  logic          done, neg_q, neg_r;
  logic [CW-1:0] cnt;
  logic          busy;

  wire sgn = ctrl[0];
  wire [DW-1:0] prod = sgn ? ({{HW{dvd[HW-1]}}, dvd[HW-1:0]} * {{HW{mpy[HW-1]}}, mpy})
                           : ({{HW{1'b0}}, dvd[HW-1:0]} * {{HW{1'b0}}, mpy});
  wire [HW:0]   shifted = {acc, quo[DW-1]};
  wire [HW:0]   diff    = shifted - {1'b0, dmag};
  wire          ge      = ~diff[HW];

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dvd <= '0; mpy <= '0; dvs <= '0; res <= '0; rem <= '0;
      ctrl <= '0; done <= 1'b0; quo <= '0; acc <= '0; dmag <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; cnt <= '0;
    end else begin
      if (rd_en && addr == A_STAT) done <= 1'b0;
      case (state)
        S_MUL: begin
          res <= prod; done <= 1'b1; state <= S_IDLE;
        end
        S_DLD: begin
          if (dvs == '0) begin
            res <= '0; rem <= dvd[HW-1:0]; done <= 1'b1; state <= S_IDLE;
          end else begin
            neg_q <= sgn & (dvd[DW-1] ^ dvs[HW-1]);
            neg_r <= sgn & dvd[DW-1];
            quo   <= (sgn & dvd[DW-1]) ? -dvd : dvd;
            dmag  <= (sgn & dvs[HW-1]) ? -dvs : dvs;
            acc   <= '0;
            cnt   <= CW'(DW);
            state <= S_DIV;
          end
        end
        S_DIV: begin
          acc <= ge ? diff[HW-1:0] : shifted[HW-1:0];
          quo <= {quo[DW-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= S_FIN;
        end
        S_FIN: begin
          res <= neg_q ? -quo : quo;
          rem <= neg_r ? -acc : acc;
          done <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (wr_en) begin
        case (addr)
          4'h0: dvd[7:0]   <= wdata;
          4'h1: dvd[15:8]  <= wdata;
          4'h2: dvd[23:16] <= wdata;
          4'h3: dvd[31:24] <= wdata;
          4'h4: mpy[7:0]   <= wdata;
          A_MPY_HI: begin
            mpy[15:8] <= wdata; state <= S_MUL; done <= 1'b0;
          end
          4'h6: dvs[7:0]   <= wdata;
          A_DVS_HI: begin
            dvs[15:8] <= wdata; state <= S_DLD; done <= 1'b0;
          end
          A_CTRL: begin
            dvd <= '0; mpy <= '0; dvs <= '0; res <= '0; rem <= '0;
            ctrl <= wdata; done <= 1'b0; state <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'h0: rdata = dvd[7:0];
      4'h1: rdata = dvd[15:8];
      4'h2: rdata = dvd[23:16];
      4'h3: rdata = dvd[31:24];
      4'h4: rdata = mpy[7:0];
      4'h5: rdata = mpy[15:8];
      4'h6: rdata = dvs[7:0];
      4'h7: rdata = dvs[15:8];
      4'h8: rdata = res[7:0];
      4'h9: rdata = res[15:8];
      4'hA: rdata = res[23:16];
      4'hB: rdata = res[31:24];
      4'hC: rdata = rem[7:0];
      4'hD: rdata = rem[15:8];
      4'hE: rdata = ctrl;
      default: rdata = done ? 8'h80 : 8'h00;
    endcase
  end
endmodule

module muldiv_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [7:0]  rdata,
  input logic        done,
  input logic        busy,
  input logic [31:0] res,
  input logic [15:0] rem
);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy));
  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 4'hF && done) |=> !done);
  // R10
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE) |=> (res == '0 && rem == '0 && !done && !busy));
  // R3
  mul_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h5) |=> (busy && !done));
  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 4'h7) |=> (busy && !done));
  // R8
  status_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'hF) |-> (rdata == 8'h00 || rdata == 8'h80));
endmodule

bind muldiv_regs muldiv_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .done(done), .busy(busy), .res(res), .rem(rem)
);

// File: tb/sim_muldiv_regs.sv
module sim_muldiv_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int nchk = 0, nfail = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  muldiv_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic rd32(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(a + 4'(i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] b;
    rd(a, b); v[7:0] = b; rd(a + 4'd1, b); v[15:8] = b;
  endtask

  function automatic logic [31:0] mulm(input logic [15:0] a, input logic [15:0] b, input bit s);
    longint x, y, p;
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    p = x * y;
    return p[31:0];
  endfunction

  function automatic logic [47:0] divm(input logic [31:0] a, input logic [15:0] b, input bit s);
    longint x, y, q, r;
    if (b == 0) return {a[15:0], 32'h0};
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    q = x / y; r = x % y;
    return {r[15:0], q[31:0]};
  endfunction

  task automatic poll(input string req);
    logic [7:0] st;
    st = 0;
    for (int i = 0; i < 40 && st != 8'h80; i++) rd(4'hF, st);
    chk(req, 32'(st), 32'h80);
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b, input bit s, input string req);
    logic [31:0] r; logic [7:0] st;
    wr(4'hE, {7'd0, s});
    wr(4'h0, a[7:0]); wr(4'h1, a[15:8]); wr(4'h4, b[7:0]); wr(4'h5, b[15:8]);
    poll({req, " R8 flag"});
    rd32(4'h8, r);
    chk({req, " R3 product"}, r, mulm(a, b, s));
    rd(4'hF, st);
    chk({req, " R9 flag cleared"}, 32'(st), 32'h0);
  endtask

  task automatic do_div(input logic [31:0] a, input logic [15:0] b, input bit s, input string req);
    logic [31:0] q; logic [15:0] r; logic [47:0] e;
    wr(4'hE, {7'd0, s});
    for (int i = 0; i < 4; i++) wr(4'(i), a[i*8 +: 8]);
    wr(4'h6, b[7:0]); wr(4'h7, b[15:8]);
    poll({req, " R8 flag"});
    rd32(4'h8, q); rd16(4'hC, r);
    e = divm(a, b, s);
    chk({req, " R5 quotient"}, q, e[31:0]);
    chk({req, " R5 remainder"}, 32'(r), 32'(e[47:32]));
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] b; logic [31:0] v; logic [15:0] h;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      chk("R1 reset value", 32'(b), 32'h0);
    end

    // R2 operand readback
    for (int a = 0; a < 8; a++) if (a != 5 && a != 7) wr(4'(a), 8'(8'h11 * (a + 1)));
    for (int a = 0; a < 8; a++) if (a != 5 && a != 7) begin
      rd(4'(a), b);
      chk("R2 readback", 32'(b), 32'(8'h11 * (a + 1)));
    end

    // R3 R4 directed multiplies
    do_mul(16'hFFFF, 16'hFFFF, 0, "R3 unsigned max");
    do_mul(16'hFFFF, 16'hFFFF, 1, "R4 signed -1*-1");
    do_mul(16'h8000, 16'h7FFF, 1, "R4 signed extremes");
    // R5 R6 R7 directed divides
    do_div(32'hFFFFFFFF, 16'h0001, 0, "R5 unsigned by one");
    do_div(32'd1000003, 16'd7, 0, "R5 unsigned");
    do_div(-32'sd7, 16'd2, 1, "R6 neg dividend");
    do_div(32'd7, -16'sd2, 1, "R6 neg divisor");
    do_div(-32'sd7, -16'sd2, 1, "R6 both neg");
    do_div(32'h80000000, 16'hFFFF, 1, "R6 min by -1");
    do_div(32'h1234ABCD, 16'h0000, 0, "R7 zero divisor unsigned");
    do_div(32'hF234ABCD, 16'h0000, 1, "R7 zero divisor signed");

    // R8 flag low while divide is running
    wr(4'hE, 8'h00);
    wr(4'h0, 8'd100); wr(4'h6, 8'd3); wr(4'h7, 8'd0);
    for (int i = 0; i < 5; i++) begin
      rd(4'hF, b);
      chk("R8 flag low while busy", 32'(b), 32'h0);
    end
    // R11 restart with new dividend
    wr(4'h0, 8'd200); wr(4'h7, 8'd0);
    poll("R11 flag");
    rd32(4'h8, v);
    chk("R11 restart quotient", v, 32'd66);
    rd16(4'hC, h);
    chk("R11 restart remainder", 32'(h), 32'd2);

    // R12 writes to result and status ignored
    wr(4'h0, 8'd9); wr(4'h6, 8'd4); wr(4'h7, 8'd0);
    repeat (40) @(posedge clk);
    wr(4'h8, 8'h55); wr(4'hC, 8'h55); wr(4'hF, 8'h00);
    rd(4'hF, b);
    chk("R12 status write ignored", 32'(b), 32'h80);
    rd32(4'h8, v);
    chk("R12 result write ignored", v, 32'd2);
    rd16(4'hC, h);
    chk("R12 remainder write ignored", 32'(h), 32'd1);

    // R10 control write clears and aborts
    wr(4'h0, 8'hFF); wr(4'h3, 8'h7F); wr(4'h6, 8'h03); wr(4'h7, 8'h00);
    repeat (3) @(posedge clk);
    wr(4'hE, 8'h01);
    repeat (40) @(posedge clk);
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), b);
      chk("R10 cleared register", 32'(b), a == 14 ? 32'h01 : 32'h0);
    end
    rd(4'hF, b);
    chk("R10 aborted no flag", 32'(b), 32'h0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ra; logic [15:0] rb; bit s;
      ra = $urandom; rb = 16'($urandom); s = 1'($urandom);
      if (n % 10 == 3) rb = 0;
      if ($urandom % 2) do_mul(ra[15:0], rb, s, "R4 random mul");
      else do_div(ra, rb, s, "R6 random div");
    end

    report();
  end
endmodule